// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block is the initiator half of a parallel SCSI bus front end. On a start pulse it captures its own 3-bit bus ID, the ID of the device it wants to reach and an attention-request flag. It then polls until the bus is free and arbitrates by driving its one-hot ID with BSY. It decides whether it won and carries out the selection hand-off. The sequencer never drives bus wires directly. It produces separate output enables for BSY, SEL, ATN and the data bus, plus the byte to place on the data lines, and leaves the pads to the surrounding logic.

Two status inputs come from the bus interface: an arbitration-in-progress indication and a lost-arbitration flag. Every wait is a cycle-count parameter: the spacing of free-bus polls, the wait for arbitration to start, the arbitration delay, the SEL-to-ID delay, the bus-settle delay and the selection timeout steps. The defaults suit a 250 MHz clock, and a bench can shrink them. Each run ends with a one-cycle done pulse. A two-bit result stays on the output until the next run finishes.

Top module: `scsi_arb_sel`

## Requirements
- R1: The arbitration word on `data_o` is the one-hot form of the captured own ID (bit `own_id_i` set). The selection word is the OR of the own and target one-hot bits.
- R2: Arbitration starts only after a poll sees `bsy_i` and `sel_i` both low. Polls are separated by at least `POLL_GAP` cycles. After `FREE_POLLS` consecutive busy polls the run ends with result 3 (reset needed), having driven nothing.
- R3: If `arb_prog_i` does not appear within `AIP_WAIT` cycles of arbitration start, drives are released and arbitration restarts from the free-bus poll.
- R4: When the arbitration delay expires, any `data_i` bit above the own ID bit ends the run with result 1 (retry). SEL is never asserted and all enables are released.
- R5: If `arb_lost_i` is high when the arbitration delay expires, arbitration restarts. This takes priority over the higher-ID check of R4.
- R6: If `arb_lost_i` is high in the first cycle with SEL driven, the run ends with result 1 (retry) and all enables are released.
- R7: SEL rises while BSY and the own ID are still driven. `atn_oe_o` follows SEL exactly when the attention flag was captured. At least `SEL_DLY` cycles later the selection word is driven with BSY for one cycle, then BSY is released while SEL and data stay driven.
- R8: After the settle delay, `bsy_i` high ends the run with result 0 (success) and releases SEL, ATN and the data drive in the same cycle.
- R9: If the target stays silent for `SEL_STEPS` steps of `STEP_CYC` cycles after settle, the run ends with result 2 (device absent).
- R10: After `ARB_RESTARTS` restarts, the next restart condition ends the run with result 3 (reset needed). A run therefore makes at most `ARB_RESTARTS`+1 arbitration attempts.
- R11: During and after reset, all enables, `busy_o` and `done_o` are low and `result_o` is 0.
- R12: `done_o` is high for exactly one cycle per run. `result_o` changes only with `done_o`. A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| own_id_i | input | 3 | Own bus ID |
| tgt_id_i | input | 3 | Target bus ID |
| atn_req_i | input | 1 | Assert ATN during selection |
| bsy_i | input | 1 | Sensed BSY line |
| sel_i | input | 1 | Sensed SEL line |
| data_i | input | 8 | Sensed data lines |
| arb_prog_i | input | 1 | Arbitration in progress indication |
| arb_lost_i | input | 1 | Lost-arbitration flag |
| bsy_oe_o | output | 1 | Drive BSY |
| sel_oe_o | output | 1 | Drive SEL |
| atn_oe_o | output | 1 | Drive ATN |
| data_oe_o | output | 1 | Drive data lines |
| data_o | output | 8 | Byte for the data lines |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 retry, 2 device absent, 3 reset needed |

## Verification
When the arbitration delay expires, the block checks two things in the same cycle: the lost-arbitration flag and the higher-ID comparison on the data lines. The bench raises both together, with a contender bit above the own ID present while the lost flag is high. The lost flag must win. This is judged by the number of arbitration attempts seen at the enables, `ARB_RESTARTS`+1, and by the final result, reset needed rather than retry. A second overlap is a target answering BSY during the settle window while SEL is still held. The bench's target responds as soon as BSY is released, and success must still be reported only after settle.

// File: rtl/sel_pkg.sv
package sel_pkg;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_RETRY  = 2'd1,
    RES_ABSENT = 2'd2,
    RES_RESET  = 2'd3
  } result_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_GAP, S_ARB, S_ADLY,
    S_SELCHK, S_SHOLD, S_SELID, S_SETTLE, S_WAIT
  } state_e;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sel_timer.sv
module sel_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sel_id_decode.sv
module sel_id_decode #(
  parameter int IDW = 3,
  localparam int DW = 1 << IDW
) (
  input  logic [IDW-1:0] own_id_i,
  input  logic [IDW-1:0] tgt_id_i,
  input  logic [DW-1:0]  data_i,
  output logic [DW-1:0]  own_oh_o,
  output logic [DW-1:0]  sel_word_o,
  output logic           higher_o
);
  logic [DW-1:0] tgt_oh;
  logic [DW-1:0] above;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign own_oh_o[i] = (own_id_i == IDW'(i));
    assign tgt_oh[i]   = (tgt_id_i == IDW'(i));
    assign above[i]    = (IDW'(i) > own_id_i);
  end

  assign sel_word_o = own_oh_o | tgt_oh;
  assign higher_o   = |(data_i & above);
endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
  import sel_pkg::*;
#(
  parameter int TW           = 16,
  parameter int FREE_POLLS   = 1000,
  parameter int POLL_GAP     = 2500,
  parameter int AIP_WAIT     = 25000,
  parameter int ARB_DLY      = 750,
  parameter int SEL_DLY      = 750,
  parameter int SETTLE_DLY   = 100,
  parameter int STEP_CYC     = 25000,
  parameter int SEL_STEPS    = 2500,
  parameter int ARB_RESTARTS = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bsy_i,
  input  logic          sel_i,
  input  logic          aip_i,
  input  logic          lost_i,
  input  logic          higher_i,
  input  logic          t_zero_i,
  output logic          t_load_o,
  output logic [TW-1:0] t_val_o,
  output logic          bsy_oe_o,
  output logic          sel_oe_o,
  output logic          data_oe_o,
  output logic          data_full_o,
  output logic          busy_o,
  output logic          done_o,
  output result_e       result_o
);
  localparam int PW = $clog2(FREE_POLLS + 1);
  localparam int RW = $clog2(ARB_RESTARTS + 1);
  localparam int SW = $clog2(SEL_STEPS + 1);

  state_e        state_q, state_d;
  logic [PW-1:0] poll_q, poll_d;
  logic [RW-1:0] rs_q, rs_d;
  logic [SW-1:0] step_q, step_d;
  result_e       res_q, res_d;
  logic          done_q, fin, restart;
  result_e       fin_res;

  always_comb begin
    state_d  = state_q;
    poll_d   = poll_q;
    rs_d     = rs_q;
    step_d   = step_q;
    res_d    = res_q;
    fin      = 1'b0;
    fin_res  = RES_OK;
    restart  = 1'b0;
    t_load_o = 1'b0;
    t_val_o  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_FREE;
        poll_d  = '0;
        rs_d    = '0;
      end
      S_FREE: begin
        if (!bsy_i && !sel_i) begin
          state_d  = S_ARB;
          t_load_o = 1'b1;
          t_val_o  = TW'(AIP_WAIT);
        end else if (poll_q == PW'(FREE_POLLS - 1)) begin
          fin     = 1'b1;
          fin_res = RES_RESET;
        end else begin
          poll_d   = poll_q + 1'b1;
          state_d  = S_GAP;
          t_load_o = 1'b1;
          t_val_o  = TW'(POLL_GAP);
        end
      end
      S_GAP: if (t_zero_i) state_d = S_FREE;
      S_ARB: begin
        if (aip_i) begin
          state_d  = S_ADLY;
          t_load_o = 1'b1;
          t_val_o  = TW'(ARB_DLY);
        end else if (t_zero_i) begin
          restart = 1'b1;
        end
      end
      S_ADLY: if (t_zero_i) begin
        // lost flag outranks the ID comparison
        if (lost_i)        restart = 1'b1;
        else if (higher_i) begin
          fin     = 1'b1;
          fin_res = RES_RETRY;
        end else           state_d = S_SELCHK;
      end
      S_SELCHK: begin
        if (lost_i) begin
          fin     = 1'b1;
          fin_res = RES_RETRY;
        end else begin
          state_d  = S_SHOLD;
          t_load_o = 1'b1;
          t_val_o  = TW'(SEL_DLY);
        end
      end
      S_SHOLD: if (t_zero_i) state_d = S_SELID;
      S_SELID: begin
        state_d  = S_SETTLE;
        t_load_o = 1'b1;
        t_val_o  = TW'(SETTLE_DLY);
      end
      S_SETTLE: if (t_zero_i) begin
        state_d  = S_WAIT;
        step_d   = '0;
        t_load_o = 1'b1;
        t_val_o  = TW'(STEP_CYC);
      end
      S_WAIT: begin
        if (bsy_i) begin
          fin     = 1'b1;
          fin_res = RES_OK;
        end else if (t_zero_i) begin
          if (step_q == SW'(SEL_STEPS - 1)) begin
            fin     = 1'b1;
            fin_res = RES_ABSENT;
          end else begin
            step_d   = step_q + 1'b1;
            t_load_o = 1'b1;
            t_val_o  = TW'(STEP_CYC);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (restart) begin
      if (rs_q == RW'(ARB_RESTARTS)) begin
        fin     = 1'b1;
        fin_res = RES_RESET;
      end else begin
        rs_d    = rs_q + 1'b1;
        poll_d  = '0;
        state_d = S_FREE;
      end
    end
    if (fin) begin
      state_d = S_IDLE;
      res_d   = fin_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      poll_q  <= '0;
      rs_q    <= '0;
      step_q  <= '0;
      res_q   <= RES_OK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      rs_q    <= rs_d;
      step_q  <= step_d;
      res_q   <= res_d;
      done_q  <= fin;
    end
  end

  assign bsy_oe_o    = state_q inside {S_ARB, S_ADLY, S_SELCHK, S_SHOLD, S_SELID};
  assign sel_oe_o    = state_q inside {S_SELCHK, S_SHOLD, S_SELID, S_SETTLE, S_WAIT};
  assign data_oe_o   = bsy_oe_o | sel_oe_o;
  assign data_full_o = state_q inside {S_SELID, S_SETTLE, S_WAIT};
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
endmodule

// File: rtl/scsi_arb_sel.sv
module scsi_arb_sel
  import sel_pkg::*;
#(
  parameter int IDW          = 3,
  parameter int FREE_POLLS   = 1000,
  parameter int POLL_GAP     = 2500,
  parameter int AIP_WAIT     = 25000,
  parameter int ARB_DLY      = 750,
  parameter int SEL_DLY      = 750,
  parameter int SETTLE_DLY   = 100,
  parameter int STEP_CYC     = 25000,
  parameter int SEL_STEPS    = 2500,
  parameter int ARB_RESTARTS = 1000,
  localparam int DW          = 1 << IDW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [IDW-1:0] own_id_i,
  input  logic [IDW-1:0] tgt_id_i,
  input  logic           atn_req_i,
  input  logic           bsy_i,
  input  logic           sel_i,
  input  logic [DW-1:0]  data_i,
  input  logic           arb_prog_i,
  input  logic           arb_lost_i,
  output logic           bsy_oe_o,
  output logic           sel_oe_o,
  output logic           atn_oe_o,
  output logic           data_oe_o,
  output logic [DW-1:0]  data_o,
  output logic           busy_o,
  output logic           done_o,
  output logic [1:0]     result_o
);
  localparam int MAXD = max_of(max_of(max_of(POLL_GAP, AIP_WAIT), max_of(ARB_DLY, SEL_DLY)),
                               max_of(SETTLE_DLY, STEP_CYC));
  localparam int TW   = $clog2(MAXD + 1);

  logic [IDW-1:0] own_q, tgt_q;
  logic           atn_q;
  logic [DW-1:0]  own_oh, sel_word;
  logic           higher, t_load, t_zero, data_full, busy;
  logic [TW-1:0]  t_val;
  result_e        res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      tgt_q <= '0;
      atn_q <= 1'b0;
    end else if (start_i && !busy) begin
      own_q <= own_id_i;
      tgt_q <= tgt_id_i;
      atn_q <= atn_req_i;
    end
  end

  sel_id_decode #(.IDW(IDW)) u_dec (
    .own_id_i   (own_q),
    .tgt_id_i   (tgt_q),
    .data_i     (data_i),
    .own_oh_o   (own_oh),
    .sel_word_o (sel_word),
    .higher_o   (higher)
  );

  sel_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  sel_fsm #(
    .TW(TW), .FREE_POLLS(FREE_POLLS), .POLL_GAP(POLL_GAP), .AIP_WAIT(AIP_WAIT),
    .ARB_DLY(ARB_DLY), .SEL_DLY(SEL_DLY), .SETTLE_DLY(SETTLE_DLY),
    .STEP_CYC(STEP_CYC), .SEL_STEPS(SEL_STEPS), .ARB_RESTARTS(ARB_RESTARTS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bsy_i       (bsy_i),
    .sel_i       (sel_i),
    .aip_i       (arb_prog_i),
    .lost_i      (arb_lost_i),
    .higher_i    (higher),
    .t_zero_i    (t_zero),
    .t_load_o    (t_load),
    .t_val_o     (t_val),
    .bsy_oe_o    (bsy_oe_o),
    .sel_oe_o    (sel_oe_o),
    .data_oe_o   (data_oe_o),
    .data_full_o (data_full),
    .busy_o      (busy),
    .done_o      (done_o),
    .result_o    (res)
  );

  assign atn_oe_o = sel_oe_o & atn_q;
  assign data_o   = !data_oe_o ? '0 : (data_full ? sel_word : own_oh);
  assign busy_o   = busy;
  assign result_o = res;
endmodule

// File: rtl/sel_checker.sv
module sel_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bsy_i,
  input logic       bsy_oe_o,
  input logic       sel_oe_o,
  input logic       atn_oe_o,
  input logic       data_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o
);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bsy_oe_o || sel_oe_o || atn_oe_o || data_oe_o));

  p_sel_after_arb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_oe_o) |-> ($past(bsy_oe_o) && bsy_oe_o && data_oe_o));

  p_atn_with_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atn_oe_o |-> sel_oe_o);

  p_sel_holds_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_oe_o |-> data_oe_o);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_moves_with_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_ok_needs_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == 2'd0) |-> $past(bsy_i));
endmodule

bind scsi_arb_sel sel_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bsy_i     (bsy_i),
  .bsy_oe_o  (bsy_oe_o),
  .sel_oe_o  (sel_oe_o),
  .atn_oe_o  (atn_oe_o),
  .data_oe_o (data_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/sim_scsi_arb_sel.sv
module sim_scsi_arb_sel;
  localparam int FP = 4, PG = 3, AW = 5, AD = 4, SD = 3, ST = 2, SC = 4, SS = 3, AR = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] own = '0, tgt = '0;
  logic       atn = 1'b0;
  logic       force_busy = 1'b0, tgt_en = 1'b0, tgt_bsy = 1'b0;
  logic       aip_en = 1'b1, lost_arb = 1'b0, lost_sel = 1'b0;
  logic [7:0] contender = '0;
  logic       bsy_i, sel_i, aip_i, lost_i;
  logic [7:0] data_i, data_o;
  logic       bsy_oe, sel_oe, atn_oe, data_oe, busy, done;
  logic [1:0] result;

  int checks = 0, fails = 0;
  int n_arb, cyc, n_done;
  logic [7:0] arb_word, sel_word;
  logic sel_seen, atn_seen, prev_arb, oe_at_done;

  always #2 clk = ~clk;

  assign bsy_i  = force_busy | bsy_oe | tgt_bsy;
  assign sel_i  = sel_oe;
  assign data_i = (data_oe ? data_o : 8'h00) | contender;
  assign aip_i  = aip_en & bsy_oe & data_oe & !sel_oe;
  assign lost_i = (lost_arb & bsy_oe & !sel_oe) | (lost_sel & sel_oe);

  always @(negedge clk)
    if (!rst_n || !tgt_en) tgt_bsy <= 1'b0;
    else tgt_bsy <= sel_oe & !bsy_oe & data_oe;

  scsi_arb_sel #(
    .IDW(3), .FREE_POLLS(FP), .POLL_GAP(PG), .AIP_WAIT(AW), .ARB_DLY(AD),
    .SEL_DLY(SD), .SETTLE_DLY(ST), .STEP_CYC(SC), .SEL_STEPS(SS), .ARB_RESTARTS(AR)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .own_id_i(own), .tgt_id_i(tgt),
    .atn_req_i(atn), .bsy_i(bsy_i), .sel_i(sel_i), .data_i(data_i),
    .arb_prog_i(aip_i), .arb_lost_i(lost_i), .bsy_oe_o(bsy_oe), .sel_oe_o(sel_oe),
    .atn_oe_o(atn_oe), .data_oe_o(data_oe), .data_o(data_o), .busy_o(busy),
    .done_o(done), .result_o(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one run; release_at/restart_at < 0 disables those events
  task automatic run(input int o, input int t, input bit a, input int release_at,
                     input int restart_at);
    own = 3'(o); tgt = 3'(t); atn = a;
    n_arb = 0; cyc = 0; n_done = 0; arb_word = '0; sel_word = '0;
    sel_seen = 0; atn_seen = 0; prev_arb = 0; oe_at_done = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 3000) begin
      cyc++;
      if (cyc == release_at) force_busy = 1'b0;
      if (cyc == restart_at) start = 1'b1; else start = 1'b0;
      if (bsy_oe && !sel_oe && !prev_arb) n_arb++;
      prev_arb = bsy_oe && !sel_oe;
      if (bsy_oe && !sel_oe) arb_word = data_o;
      if (sel_oe && bsy_oe) sel_word = data_o;
      if (sel_oe) sel_seen = 1;
      if (atn_oe) atn_seen = 1;
      if (!done) @(negedge clk);
    end
    start = 1'b0;
    if (!done) check(0, "watchdog", cyc, 0);
    oe_at_done = bsy_oe | sel_oe | atn_oe | data_oe;
    @(negedge clk);
    check(!done, "R12 done one cycle", done, 0);
    tgt_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!(bsy_oe | sel_oe | atn_oe | data_oe), "R11 enables in reset", 1, 0);
    check(!busy && !done && result == 2'd0, "R11 status in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && result == 2'd0, "R11 after reset", result, 0);

    // R1 R7 R8: full sweep of own/target/atn
    for (int o = 0; o < 8; o++)
      for (int t = 0; t < 8; t++)
        for (int a = 0; a < 2; a++) begin
          if (o == t) continue;
          tgt_en = 1;
          run(o, t, a[0], -1, -1);
          check(result == 2'd0, "R8 success", result, 0);
          check(!oe_at_done, "R8 drives released", oe_at_done, 0);
          check(arb_word == 8'(1 << o), "R1 arb word", arb_word, 1 << o);
          check(sel_word == 8'((1 << o) | (1 << t)), "R1 sel word", sel_word, (1 << o) | (1 << t));
          check(atn_seen == a[0], "R7 atn", atn_seen, a);
          check(n_arb == 1, "R7 single attempt", n_arb, 1);
        end

    // R4: contender above own wins, below loses
    for (int o = 0; o < 8; o++)
      for (int p = 0; p < 8; p++) begin
        if (p == o) continue;
        contender = 8'(1 << p);
        tgt_en = 1;
        run(o, (o + 1) % 8, 0, -1, -1);
        check(result == ((p > o) ? 2'd1 : 2'd0), "R4 priority", result, (p > o) ? 1 : 0);
        check(sel_seen == !(p > o), "R4 sel asserted", sel_seen, !(p > o));
        check(!oe_at_done, "R4 released", oe_at_done, 0);
      end
    contender = '0;

    // R6: lost flag right after SEL
    lost_sel = 1; tgt_en = 1;
    run(2, 5, 1, -1, -1);
    check(result == 2'd1 && sel_seen, "R6 lost after sel", result, 1);
    check(!oe_at_done, "R6 released", oe_at_done, 0);
    lost_sel = 0;

    // R5 R10: lost at delay restarts until limit
    lost_arb = 1; tgt_en = 1;
    run(3, 1, 0, -1, -1);
    check(result == 2'd3, "R10 reset needed", result, 3);
    check(n_arb == AR + 1, "R5 restarts", n_arb, AR + 1);
    // R5: lost flag outranks a higher contender
    contender = 8'h80;
    run(3, 1, 0, -1, -1);
    check(result == 2'd3, "R5 lost over contender", result, 3);
    check(n_arb == AR + 1 && !sel_seen, "R5 attempts", n_arb, AR + 1);
    contender = '0; lost_arb = 0;

    // R3: arbitration never starts
    aip_en = 0;
    run(4, 0, 0, -1, -1);
    check(result == 2'd3, "R3 reset after no aip", result, 3);
    check(n_arb == AR + 1, "R3 attempts", n_arb, AR + 1);
    check(cyc >= (AR + 1) * AW, "R3 wait length", cyc, (AR + 1) * AW);
    aip_en = 1;

    // R2: bus stays busy
    force_busy = 1;
    run(1, 2, 0, -1, -1);
    check(result == 2'd3 && n_arb == 0, "R2 busy bus", result, 3);
    check(cyc >= (FP - 1) * (PG + 1), "R2 poll spacing", cyc, (FP - 1) * (PG + 1));
    // R2: bus frees after a few polls
    force_busy = 1; tgt_en = 1;
    run(1, 2, 0, 6, -1);
    check(result == 2'd0 && n_arb == 1, "R2 free later", result, 0);
    force_busy = 0;

    // R9: target absent
    tgt_en = 0;
    run(6, 7, 1, -1, -1);
    check(result == 2'd2, "R9 absent", result, 2);
    check(cyc >= SS * SC, "R9 timeout length", cyc, SS * SC);

    // R12: start during run ignored, result held afterwards
    tgt_en = 1;
    run(0, 7, 0, -1, 5);
    check(result == 2'd0 && n_arb == 1, "R12 start ignored", n_arb, 1);
    repeat (10) @(negedge clk);
    check(!busy && result == 2'd0, "R12 result held", result, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule